// File: doc/BRIEF.md
# Cache line fill burst order generator

This block turns a cache miss into the sequence of word addresses that a line fill burst visits. A single start pulse brings in the word address that missed together with an order select. From the next cycle on, the block presents one beat address at a time and steps to the next beat on each cycle in which the consumer raises the advance input. After the fourth beat it drops back to idle. The address above the line is held fixed for the whole burst, and the byte-within-beat bits are always driven to zero.

Four orders are available:
- **Linear** always begins at word zero.
- **Wrap** begins at the missed word and wraps around the line.
- **Pairwise interleave** finishes the aligned two-word half that holds the missed word before touching the other half.
- **Mask** lets the caller choose any order. It supplies, for each beat, which beat-select bits are inverted relative to the missed word's offset.

In mask mode, a mask set that would revisit a word raises an error flag for the burst.

Top module: `burst_order_gen`

## Requirements
- R1: After reset, `valid_o`, `first_o`, `last_o` and `map_err_o` are all 0.
- R2: A start pulse accepted while idle makes `valid_o` 1 on the next cycle, with `first_o` = 1 on that beat only. The beat index moves on only in cycles where `adv_i` is 1, and holds otherwise.
- R3: With `mode_i` = 2'b00 (linear), the beat offsets are 0, 1, 2, 3, whatever the missed word.
- R4: With `mode_i` = 2'b01 (wrap), beat k has offset (s + k) mod 4, where s is the missed word offset, `start_addr_i[1:0]`.
- R5: With `mode_i` = 2'b10 (pairwise), beat k has offset s XOR k. Both words of the half holding s therefore come before the other half.
- R6: With `mode_i` = 2'b11 (mask), beat k has offset s XOR m_k. Here m_k is `mask_i[2k+1:2k]`, captured at start.
- R7: `map_err_o` is 1 for the whole of a mask-mode burst whose four masks are not all different. It is 0 for any other burst.
- R8: `beat_addr_o` carries the line address from `start_addr_i` unchanged in bits [31:5], the beat offset in bits [4:3], and zeros in bits [2:0].
- R9: A start pulse that arrives while a burst is active has no effect on the offsets, address or flags of that burst.
- R10: `last_o` is 1 on the fourth beat only. After `adv_i` is taken on that beat, `valid_o` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a new burst (taken only when idle) |
| start_addr_i | input | 29 | Word address of the miss (byte bits excluded) |
| mode_i | input | 2 | Order select: 0 linear, 1 wrap, 2 pairwise, 3 mask |
| mask_i | input | 8 | Four per-beat 2-bit inversion masks, beat k at [2k+1:2k] |
| adv_i | input | 1 | Consumer accepts the current beat |
| valid_o | output | 1 | A beat address is presented |
| offset_o | output | 2 | Word offset of the current beat |
| beat_addr_o | output | 32 | Full byte address of the current beat |
| first_o | output | 1 | Current beat is the first |
| last_o | output | 1 | Current beat is the last |
| map_err_o | output | 1 | Mask set of this burst revisits a word |

## Verification
The bench uses the default build: 32-bit addresses, 8-byte beats and a four-beat line. At that size every start offset can be combined with every order. In mask mode, the bench sweeps all 256 mask sets at each of the four start offsets, so every permutation and every duplicate pattern is seen together with the error flag. Stalls are placed at beat positions that vary from burst to burst, so every beat is observed both held and advanced.

// File: rtl/burst_order_pkg.sv
// Shared types for the burst order generator.
// Assumes a two-bit order select at the block boundary.
package burst_order_pkg;
    typedef enum logic [1:0] {
        ORD_LINEAR = 2'b00,
        ORD_WRAP   = 2'b01,
        ORD_PAIR   = 2'b10,
        ORD_MASK   = 2'b11
    } order_e;
endpackage

// File: rtl/burst_beat_ctl.sv
// Beat sequencer: tracks whether a burst is running and which beat is shown.
// Assumes the consumer steps one beat per cycle with adv_i high; a start is
// taken only when no burst is running.
module burst_beat_ctl #(
    parameter int SEL_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                adv_i,
    output logic                accept_o,
    output logic                busy_o,
    output logic [SEL_BITS-1:0] cnt_o,
    output logic                first_o,
    output logic                last_o
);
    localparam int BEATS = 1 << SEL_BITS;
    localparam logic [SEL_BITS-1:0] LAST_IDX = SEL_BITS'(BEATS - 1);

    logic                busy_q;
    logic [SEL_BITS-1:0] cnt_q;

    // Accept a start only while idle.
    assign accept_o = start_i & ~busy_q;

    // Busy flag and beat index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q && adv_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) busy_q <= 1'b0;
        end
    end

    assign busy_o  = busy_q;
    assign cnt_o   = cnt_q;
    assign first_o = busy_q && (cnt_q == '0);
    assign last_o  = busy_q && (cnt_q == LAST_IDX);

    // R2: an accepted start opens the burst on beat zero.
    p_open_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (busy_o && cnt_o == '0));

    // R2: without advance the beat index holds.
    p_hold_no_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !adv_i) |=> (busy_o && $stable(cnt_o)));

    // R10: advance on the last beat ends the burst.
    p_close_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i) |=> !busy_o);
endmodule

// File: rtl/burst_order_map.sv
// Offset mapper: turns the captured start offset, order and beat index into
// the word offset of the current beat. Purely combinational.
module burst_order_map
    import burst_order_pkg::*;
#(
    parameter int SEL_BITS = 2
) (
    input  order_e                          mode_i,
    input  logic [SEL_BITS-1:0]             soff_i,
    input  logic [SEL_BITS-1:0]             cnt_i,
    input  logic [(SEL_BITS<<SEL_BITS)-1:0] masks_i,
    output logic [SEL_BITS-1:0]             off_o
);
    localparam int BEATS = 1 << SEL_BITS;

    logic [SEL_BITS-1:0] mask_sel;

    // Pick the inversion mask belonging to the current beat.
    always_comb begin
        mask_sel = '0;
        for (int b = 0; b < BEATS; b++) begin
            if (cnt_i == SEL_BITS'(b)) mask_sel = masks_i[b*SEL_BITS +: SEL_BITS];
        end
    end

    // Combine start offset and beat index per the chosen order.
    always_comb begin
        unique case (mode_i)
            ORD_LINEAR: off_o = cnt_i;
            ORD_WRAP:   off_o = soff_i + cnt_i;
            ORD_PAIR:   off_o = soff_i ^ cnt_i;
            ORD_MASK:   off_o = soff_i ^ mask_sel;
            default:    off_o = cnt_i;
        endcase
    end
endmodule

// File: rtl/burst_mask_check.sv
// Mask coverage check: flags a mask set in which any two beats share a mask,
// which means some word would be fetched twice and another never.
module burst_mask_check #(
    parameter int SEL_BITS = 2
) (
    input  logic [(SEL_BITS<<SEL_BITS)-1:0] masks_i,
    output logic                            dup_o
);
    localparam int BEATS = 1 << SEL_BITS;
    localparam int PAIRS = BEATS * BEATS;

    logic [PAIRS-1:0] hit;

    // One comparator per ordered pair with i < j.
    for (genvar i = 0; i < BEATS; i++) begin : g_row
        for (genvar j = 0; j < BEATS; j++) begin : g_col
            if (j > i) begin : g_cmp
                assign hit[i*BEATS+j] =
                    (masks_i[i*SEL_BITS +: SEL_BITS] == masks_i[j*SEL_BITS +: SEL_BITS]);
            end else begin : g_none
                assign hit[i*BEATS+j] = 1'b0;
            end
        end
    end

    assign dup_o = |hit;
endmodule

// File: rtl/burst_order_gen.sv
// Top of the line fill burst order generator. Captures the miss address,
// order and masks on an accepted start, then presents one beat address per
// advance. Assumes a line of 2**SEL_BITS beats of 2**BYTE_BITS bytes.
module burst_order_gen
    import burst_order_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BYTE_BITS = 3,
    parameter int SEL_BITS  = 2,
    localparam int BEATS    = 1 << SEL_BITS,
    localparam int MASK_W   = SEL_BITS * BEATS,
    localparam int WORD_W   = ADDR_W - BYTE_BITS,
    localparam int LINE_LSB = BYTE_BITS + SEL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [WORD_W-1:0]   start_addr_i,
    input  logic [1:0]          mode_i,
    input  logic [MASK_W-1:0]   mask_i,
    input  logic                adv_i,
    output logic                valid_o,
    output logic [SEL_BITS-1:0] offset_o,
    output logic [ADDR_W-1:0]   beat_addr_o,
    output logic                first_o,
    output logic                last_o,
    output logic                map_err_o
);
    logic                       accept;
    logic                       busy;
    logic [SEL_BITS-1:0]        cnt;
    logic                       dup;
    order_e                     mode_q;
    logic [SEL_BITS-1:0]        soff_q;
    logic [MASK_W-1:0]          masks_q;
    logic [ADDR_W-LINE_LSB-1:0] line_q;
    logic                       err_q;

    burst_beat_ctl #(.SEL_BITS(SEL_BITS)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .adv_i    (adv_i),
        .accept_o (accept),
        .busy_o   (busy),
        .cnt_o    (cnt),
        .first_o  (first_o),
        .last_o   (last_o)
    );

    burst_mask_check #(.SEL_BITS(SEL_BITS)) u_chk (
        .masks_i (mask_i),
        .dup_o   (dup)
    );

    burst_order_map #(.SEL_BITS(SEL_BITS)) u_map (
        .mode_i  (mode_q),
        .soff_i  (soff_q),
        .cnt_i   (cnt),
        .masks_i (masks_q),
        .off_o   (offset_o)
    );

    // Capture the burst context on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= ORD_LINEAR;
            soff_q  <= '0;
            masks_q <= '0;
            line_q  <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            mode_q  <= order_e'(mode_i);
            soff_q  <= start_addr_i[SEL_BITS-1:0];
            masks_q <= mask_i;
            line_q  <= start_addr_i[WORD_W-1:SEL_BITS];
            err_q   <= (order_e'(mode_i) == ORD_MASK) && dup;
        end
    end

    assign valid_o     = busy;
    assign map_err_o   = busy && err_q;
    assign beat_addr_o = {line_q, offset_o, {BYTE_BITS{1'b0}}};

    // R8: the line address does not move inside a burst.
    p_line_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !(adv_i && last_o)) |=> $stable(beat_addr_o[ADDR_W-1:LINE_LSB]));

    // R8: byte bits of the beat address are zero.
    p_byte_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (beat_addr_o[BYTE_BITS-1:0] == '0));

    // R9: a start during a burst leaves the running context alone.
    p_ignore_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && start_i && !(adv_i && last_o)) |=>
            ($stable(soff_q) && $stable(mode_q) && $stable(masks_q)));

    // R7: only mask mode can report an uncovered line.
    p_err_mask_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mode_q != ORD_MASK) |-> !map_err_o);

    // R5: the first two beats of a pairwise burst stay in the critical half.
    p_pair_half_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mode_q == ORD_PAIR && !cnt[SEL_BITS-1])
            |-> (offset_o[SEL_BITS-1] == soff_q[SEL_BITS-1]));

    // R1/R2: flags only appear while a beat is presented.
    p_flags_need_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (first_o || last_o || map_err_o) |-> valid_o);
endmodule

// File: tb/burst_order_gen_bench.sv
module burst_order_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [28:0] start_addr_i = '0;
    logic [1:0]  mode_i = '0;
    logic [7:0]  mask_i = '0;
    logic        adv_i = 1'b0;
    logic        valid_o;
    logic [1:0]  offset_o;
    logic [31:0] beat_addr_o;
    logic        first_o, last_o, map_err_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    burst_order_gen u_burst_order_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .mode_i(mode_i), .mask_i(mask_i), .adv_i(adv_i), .valid_o(valid_o),
        .offset_o(offset_o), .beat_addr_o(beat_addr_o), .first_o(first_o),
        .last_o(last_o), .map_err_o(map_err_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_off(input int mode, input int s, input int k,
                                           input logic [7:0] m);
        case (mode)
            0: return 2'(k);
            1: return 2'(s + k);
            2: return 2'(s ^ k);
            default: return 2'(s) ^ m[2*k +: 2];
        endcase
    endfunction

    function automatic bit masks_dup(input logic [7:0] m);
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                if (m[2*i +: 2] == m[2*j +: 2]) return 1;
        return 0;
    endfunction

    // Check one presented beat against the expected values.
    task automatic check_beat(input int mode, input int s, input int k, input logic [7:0] m,
                              input logic [28:0] wa, input bit exp_err);
        logic [1:0] eo;
        eo = exp_off(mode, s, k, m);
        chk(valid_o == 1'b1, "R2 valid", valid_o, 1);
        case (mode)
            0: chk(offset_o == eo, "R3 linear offset", offset_o, eo);
            1: chk(offset_o == eo, "R4 wrap offset", offset_o, eo);
            2: chk(offset_o == eo, "R5 pair offset", offset_o, eo);
            default: chk(offset_o == eo, "R6 mask offset", offset_o, eo);
        endcase
        chk(beat_addr_o == {wa[28:2], eo, 3'b000}, "R8 beat addr", beat_addr_o,
            {wa[28:2], eo, 3'b000});
        chk(first_o == (k == 0), "R2 first flag", first_o, k == 0);
        chk(last_o == (k == 3), "R10 last flag", last_o, k == 3);
        chk(map_err_o == exp_err, "R7 map err", map_err_o, exp_err);
    endtask

    // Run one full burst; stall pattern varies with seed; optional busy start.
    task automatic run_burst(input int mode, input logic [28:0] wa, input logic [7:0] m,
                             input int seed, input bit poke);
        bit e;
        int s;
        s = int'(wa[1:0]);
        e = (mode == 3) && masks_dup(m);
        start_i = 1'b1; start_addr_i = wa; mode_i = 2'(mode); mask_i = m; adv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (((seed + k) % 3) == 0) begin
                adv_i = 1'b0;
                if (poke) begin
                    start_i = 1'b1; start_addr_i = ~wa; mode_i = 2'(mode + 1); mask_i = ~m;
                end
                @(negedge clk);
                start_i = 1'b0;
                check_beat(mode, s, k, m, wa, e);
            end
            adv_i = 1'b1;
            if (poke && k == 1) begin
                start_i = 1'b1; start_addr_i = ~wa; mode_i = 2'(mode + 2); mask_i = 8'h00;
            end
            check_beat(mode, s, k, m, wa, e);
            @(negedge clk);
            start_i = 1'b0;
        end
        adv_i = 1'b0;
        chk(valid_o == 1'b0, "R10 idle after last", valid_o, 0);
        chk(first_o == 1'b0 && last_o == 1'b0, "R10 flags clear", {first_o, last_o}, 0);
    endtask

    initial begin
        int seed;
        seed = 0;
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0, "R1 valid reset", valid_o, 0);
        chk(first_o == 1'b0 && last_o == 1'b0, "R1 flags reset", {first_o, last_o}, 0);
        chk(map_err_o == 1'b0, "R1 err reset", map_err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Fixed orders, all start offsets, several line addresses (R3 R4 R5).
        for (int mode = 0; mode < 3; mode++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 3; a++) begin
                    run_burst(mode, {27'(32'h0123457 * (a + 1) + a), 2'(s)}, 8'hA5, seed, 0);
                    seed++;
                end
        // Mask mode: every mask set at every start offset (R6 R7).
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 256; m++) begin
                run_burst(3, {27'(32'h5A5A5A5 + m), 2'(s)}, 8'(m), seed, 0);
                seed++;
            end
        // Starts issued while busy (R9), with a non-mask burst after a bad mask (R7).
        run_burst(3, 29'h1000_0002, 8'h00, 0, 0);
        run_burst(1, 29'h0ABC_DEF1, 8'h00, 0, 1);
        run_burst(2, 29'h1357_9BDF, 8'h1B, 1, 1);
        run_burst(3, 29'h0246_8ACE, 8'hE4, 2, 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule